// File: doc/BRIEF.md
# Operand Address Generation Unit

This block turns one six-bit operand specifier into either a register selection or a memory effective address. The specifier has a three-bit addressing mode and a three-bit register number, and a byte/word flag comes with it. The block reads the selected register from an external eight-entry register file. For the modes that need them, it issues extra word reads on a memory read port. These reads are an index word taken at the program counter, or a pointer fetched from the computed address. The block also works out the register update (post-increment, pre-decrement or program-counter advance) and commits it in the same cycle as the result.

The FSM has six states:
- `ST_IDLE` waits for `start`. `IDLE->FINISH` is taken for modes 0, 1, 2 and 4. `IDLE->PTR_REQ` is taken for modes 3 and 5. `IDLE->IDX_REQ` is taken for modes 6 and 7.
- `ST_IDX_REQ` presents the program counter as a read address. `IDX_REQ->IDX_WAIT` is taken on handshake. `IDX_REQ->FINISH` is taken on an odd counter.
- `ST_IDX_WAIT` takes the index word. `IDX_WAIT->FINISH` is taken for mode 6 and `IDX_WAIT->PTR_REQ` for mode 7.
- `ST_PTR_REQ` requests the pointer word. `PTR_REQ->PTR_WAIT` is taken on handshake. `PTR_REQ->FINISH` is taken on an odd address.
- `ST_PTR_WAIT` takes the pointer. `PTR_WAIT->FINISH` is taken on response.
- `ST_FINISH` raises `done` or `odd_fault` for one cycle. `FINISH->IDLE` is always taken.

Top module: `oagu_operand_addr`

## Requirements
- R1: Mode 0 raises `done` on the clock edge after the one that samples `start`. `ea_is_reg` is 1, `ea` equals the register number zero-extended, and no register is written.
- R2: Mode 1 gives `ea` equal to the register contents after one cycle, with no register write.
- R3: Mode 2 gives `ea` equal to the old register value and writes back old+step. Mode 4 gives `ea` and the write-back both equal to old−step. The step is 1 for byte accesses (`is_byte`=1) and 2 for word accesses.
- R4: Register 6 and register 7 always step by 2, even when `is_byte` is 1.
- R5: Modes 3 and 5 read one word at the old value (mode 3) or at old−2 (mode 5). The register is written to old+2 (mode 3) or old−2 (mode 5), and `ea` equals the word read.
- R6: Modes 6 and 7 read an index word at the address held in register 7 and write register 7 to that address plus 2. Mode 6 gives `ea` = index + register. Mode 7 gives `ea` equal to the word read at that sum.
- R7: When modes 6 or 7 name register 7 itself, the base added to the index is the advanced counter (fetch address + 2). Modes 2 and 3 on register 7 therefore act as immediate and absolute addressing.
- R8: Two conditions end an operation with a one-cycle `odd_fault` instead of `done`, and with no register write. The first is a word access (`is_byte`=0, mode not 0) whose final `ea` is odd. The second is any required memory read at an odd address, and no such read is ever requested. A byte access may end on an odd `ea`.
- R9: `done` lasts exactly one cycle, and `rf_we` is high only in the `done` cycle.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address are held. Any response latency is accepted.
- R11: A `start` pulse that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin resolving the specifier (sampled in idle only) |
| spec_mode | input | 3 | Addressing mode 0..7 |
| spec_reg | input | 3 | Register number 0..7 |
| is_byte | input | 1 | 1 = byte access, 0 = word access |
| rf_rd_sel | output | 3 | Register file read select |
| rf_rd_data | input | 16 | Register file read data (combinational) |
| rf_we | output | 1 | Register write-back enable |
| rf_wr_sel | output | 3 | Register write-back select |
| rf_wr_data | output | 16 | Register write-back value |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 16 | Memory read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 16 | Read data word |
| ea | output | 16 | Effective address, or register number in mode 0 |
| ea_is_reg | output | 1 | Operand is a register |
| done | output | 1 | One-cycle completion pulse |
| odd_fault | output | 1 | One-cycle odd-address fault pulse |

## Verification
In the indexed modes, the program-counter advance and the address sum happen in the same response cycle. When the base register is the counter itself, the sum must use the advanced value. Directed relative and relative-deferred cases on register 7 provoke this, and the bench compares `ea` and the final counter with values from its own model. The register write-back also shares its cycle with `done`. After each operation the bench compares all eight registers with its prediction. A stray `start` is also pulsed while memory reads are outstanding, and the outcome must match the original specifier.

// File: rtl/oagu_pkg.sv
package oagu_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IDX_REQ,
        ST_IDX_WAIT,
        ST_PTR_REQ,
        ST_PTR_WAIT,
        ST_FINISH
    } oagu_state_e;

    typedef enum logic [2:0] {
        AM_REG         = 3'd0,
        AM_REG_DEF     = 3'd1,
        AM_POSTINC     = 3'd2,
        AM_POSTINC_DEF = 3'd3,
        AM_PREDEC      = 3'd4,
        AM_PREDEC_DEF  = 3'd5,
        AM_INDEX       = 3'd6,
        AM_INDEX_DEF   = 3'd7
    } oagu_mode_e;
endpackage

// File: rtl/oagu_step_calc.sv
module oagu_step_calc
    import oagu_pkg::*;
#(
    parameter int DW     = 16,
    parameter int RB     = 3,
    parameter int SP_IDX = 6,
    parameter int PC_IDX = 7
) (
    input  oagu_mode_e      mode,
    input  logic [RB-1:0]   sel,
    input  logic            is_byte,
    input  logic [DW-1:0]   base,
    output logic [DW-1:0]   access_addr,
    output logic [DW-1:0]   new_val,
    output logic            updates
);
    localparam logic [DW-1:0] STEP_ONE = DW'(1);
    localparam logic [DW-1:0] STEP_TWO = DW'(2);

    logic            deferred;
    logic            wide_step;
    logic [DW-1:0]   step;

    always_comb begin
        deferred  = (mode == AM_POSTINC_DEF) || (mode == AM_PREDEC_DEF);
        wide_step = deferred || !is_byte
                    || (sel == RB'(SP_IDX)) || (sel == RB'(PC_IDX));
        step      = wide_step ? STEP_TWO : STEP_ONE;
        unique case (mode)
            AM_POSTINC, AM_POSTINC_DEF: begin
                access_addr = base;
                new_val     = base + step;
                updates     = 1'b1;
            end
            AM_PREDEC, AM_PREDEC_DEF: begin
                access_addr = base - step;
                new_val     = base - step;
                updates     = 1'b1;
            end
            default: begin
                access_addr = base;
                new_val     = base;
                updates     = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/oagu_index_sum.sv
module oagu_index_sum #(
    parameter int DW     = 16,
    parameter int RB     = 3,
    parameter int PC_IDX = 7
) (
    input  logic [DW-1:0] index_word,
    input  logic [DW-1:0] base,
    input  logic [DW-1:0] pc_fetch,
    input  logic [RB-1:0] sel,
    output logic [DW-1:0] sum,
    output logic [DW-1:0] pc_next
);
    localparam logic [DW-1:0] PC_STEP = DW'(2);

    always_comb begin
        pc_next = pc_fetch + PC_STEP;
        sum     = index_word + ((sel == RB'(PC_IDX)) ? pc_next : base);
    end
endmodule

// File: rtl/oagu_operand_addr.sv
module oagu_operand_addr
    import oagu_pkg::*;
#(
    parameter int DW     = 16,
    parameter int RB     = 3,
    parameter int SP_IDX = 6,
    parameter int PC_IDX = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    spec_mode,
    input  logic [RB-1:0] spec_reg,
    input  logic          is_byte,
    output logic [RB-1:0] rf_rd_sel,
    input  logic [DW-1:0] rf_rd_data,
    output logic          rf_we,
    output logic [RB-1:0] rf_wr_sel,
    output logic [DW-1:0] rf_wr_data,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [DW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic [DW-1:0] ea,
    output logic          ea_is_reg,
    output logic          done,
    output logic          odd_fault
);
    oagu_state_e   state_q, state_n;
    oagu_mode_e    mode_q, mode_in;
    logic [RB-1:0] reg_q;
    logic          byte_q;
    logic          is_reg_q;
    logic          fault_q;
    logic [DW-1:0] addr_q;
    logic [DW-1:0] base_q;
    logic [DW-1:0] pc_q;
    logic          wb_en_q;
    logic [RB-1:0] wb_sel_q;
    logic [DW-1:0] wb_data_q;
    logic          final_bad;

    logic [DW-1:0] sc_addr, sc_new;
    logic          sc_upd;
    logic [DW-1:0] ix_sum, ix_pc_next;

    assign mode_in = oagu_mode_e'(spec_mode);

    oagu_step_calc #(.DW(DW), .RB(RB), .SP_IDX(SP_IDX), .PC_IDX(PC_IDX)) u_step (
        .mode        (mode_in),
        .sel         (spec_reg),
        .is_byte     (is_byte),
        .base        (rf_rd_data),
        .access_addr (sc_addr),
        .new_val     (sc_new),
        .updates     (sc_upd)
    );

    oagu_index_sum #(.DW(DW), .RB(RB), .PC_IDX(PC_IDX)) u_idx (
        .index_word (mem_rsp_data),
        .base       (base_q),
        .pc_fetch   (pc_q),
        .sel        (reg_q),
        .sum        (ix_sum),
        .pc_next    (ix_pc_next)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    unique case (mode_in)
                        AM_POSTINC_DEF, AM_PREDEC_DEF: state_n = ST_PTR_REQ;
                        AM_INDEX, AM_INDEX_DEF:        state_n = ST_IDX_REQ;
                        default:                       state_n = ST_FINISH;
                    endcase
                end
            end
            ST_IDX_REQ: begin
                if (rf_rd_data[0])      state_n = ST_FINISH;
                else if (mem_req_ready) state_n = ST_IDX_WAIT;
            end
            ST_IDX_WAIT: begin
                if (mem_rsp_valid)
                    state_n = (mode_q == AM_INDEX_DEF) ? ST_PTR_REQ : ST_FINISH;
            end
            ST_PTR_REQ: begin
                if (addr_q[0])          state_n = ST_FINISH;
                else if (mem_req_ready) state_n = ST_PTR_WAIT;
            end
            ST_PTR_WAIT: begin
                if (mem_rsp_valid) state_n = ST_FINISH;
            end
            ST_FINISH: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= AM_REG;
            reg_q     <= '0;
            byte_q    <= 1'b0;
            is_reg_q  <= 1'b0;
            fault_q   <= 1'b0;
            addr_q    <= '0;
            base_q    <= '0;
            pc_q      <= '0;
            wb_en_q   <= 1'b0;
            wb_sel_q  <= '0;
            wb_data_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mode_q    <= mode_in;
                        reg_q     <= spec_reg;
                        byte_q    <= is_byte;
                        fault_q   <= 1'b0;
                        base_q    <= rf_rd_data;
                        is_reg_q  <= (mode_in == AM_REG);
                        addr_q    <= (mode_in == AM_REG) ? DW'(spec_reg) : sc_addr;
                        wb_en_q   <= sc_upd;
                        wb_sel_q  <= spec_reg;
                        wb_data_q <= sc_new;
                    end
                end
                ST_IDX_REQ: begin
                    pc_q <= rf_rd_data;
                    if (rf_rd_data[0]) fault_q <= 1'b1;
                end
                ST_IDX_WAIT: begin
                    if (mem_rsp_valid) begin
                        addr_q    <= ix_sum;
                        wb_en_q   <= 1'b1;
                        wb_sel_q  <= RB'(PC_IDX);
                        wb_data_q <= ix_pc_next;
                    end
                end
                ST_PTR_REQ: begin
                    if (addr_q[0]) fault_q <= 1'b1;
                end
                ST_PTR_WAIT: begin
                    if (mem_rsp_valid) addr_q <= mem_rsp_data;
                end
                ST_FINISH: fault_q <= 1'b0;
                default: ;
            endcase
        end
    end

    assign final_bad = fault_q || (!byte_q && !is_reg_q && addr_q[0]);

    // outputs
    always_comb begin
        rf_rd_sel     = reg_q;
        mem_req_valid = 1'b0;
        mem_req_addr  = addr_q;
        done          = 1'b0;
        odd_fault     = 1'b0;
        rf_we         = 1'b0;
        unique case (state_q)
            ST_IDLE:    rf_rd_sel = spec_reg;
            ST_IDX_REQ: begin
                rf_rd_sel     = RB'(PC_IDX);
                mem_req_addr  = rf_rd_data;
                mem_req_valid = !rf_rd_data[0];
            end
            ST_PTR_REQ: mem_req_valid = !addr_q[0];
            ST_FINISH: begin
                done      = !final_bad;
                odd_fault = final_bad;
                rf_we     = wb_en_q && !final_bad;
            end
            default: ;
        endcase
    end

    assign rf_wr_sel  = wb_sel_q;
    assign rf_wr_data = wb_data_q;
    assign ea         = addr_q;
    assign ea_is_reg  = is_reg_q;

    // assertions
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_we_in_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> done);
    assert_fault_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && odd_fault));
    assert_word_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ea_is_reg && !byte_q) |-> !ea[0]);
    assert_no_odd_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !mem_req_addr[0]);
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    assert_reg_no_wb_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ea_is_reg) |-> !rf_we);
endmodule

// File: tb/test_oagu_operand_addr.sv
module test_oagu_operand_addr;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  spec_mode = '0;
    logic [2:0]  spec_reg = '0;
    logic        is_byte = 1'b0;
    logic [2:0]  rf_rd_sel;
    logic [15:0] rf_rd_data;
    logic        rf_we;
    logic [2:0]  rf_wr_sel;
    logic [15:0] rf_wr_data;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [15:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [15:0] mem_rsp_data;
    logic [15:0] ea;
    logic        ea_is_reg;
    logic        done;
    logic        odd_fault;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oagu_operand_addr i_oagu_operand_addr (
        .clk(clk), .rst_n(rst_n), .start(start), .spec_mode(spec_mode),
        .spec_reg(spec_reg), .is_byte(is_byte), .rf_rd_sel(rf_rd_sel),
        .rf_rd_data(rf_rd_data), .rf_we(rf_we), .rf_wr_sel(rf_wr_sel),
        .rf_wr_data(rf_wr_data), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .ea(ea), .ea_is_reg(ea_is_reg), .done(done), .odd_fault(odd_fault)
    );

    // register file model
    logic [15:0] rf [8];
    logic [15:0] load_img [8];
    logic        load_en = 1'b0;
    assign rf_rd_data = rf[rf_rd_sel];
    always @(posedge clk) begin
        if (load_en) rf <= load_img;
        else if (rf_we) rf[rf_wr_sel] <= rf_wr_data;
    end

    function automatic logic [15:0] mem_f(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h2468;
    endfunction

    // memory model with random ready and latency
    logic        pend = 1'b0;
    logic [15:0] paddr = '0;
    int          lat = 0;
    logic        odd_seen = 1'b0;
    logic        rdy = 1'b0;
    logic        rv = 1'b0;
    logic [15:0] rd = '0;
    assign mem_req_ready = rdy;
    assign mem_rsp_valid = rv;
    assign mem_rsp_data  = rd;
    always @(posedge clk) begin
        rv <= 1'b0;
        if (mem_req_valid && mem_req_addr[0]) odd_seen <= 1'b1;
        if (pend) begin
            if (lat == 0) begin
                rv <= 1'b1; rd <= mem_f(paddr); pend <= 1'b0;
            end else lat <= lat - 1;
        end else if (mem_req_valid && rdy) begin
            pend <= 1'b1; paddr <= mem_req_addr; lat <= int'($urandom % 3);
        end
        rdy <= !pend && (($urandom % 4) != 0);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // expected result from the requirements
    task automatic predict(input logic [2:0] m, input logic [2:0] r, input logic b,
                           output logic e_err, output logic [15:0] e_ea,
                           output logic e_reg, output logic e_wb,
                           output logic [2:0] e_sel, output logic [15:0] e_val);
        logic [15:0] base, step, ptr, pc, sum;
        base = load_img[r];
        step = (m == 3 || m == 5 || !b || r >= 6) ? 16'd2 : 16'd1;
        e_err = 1'b0; e_reg = 1'b0; e_wb = 1'b0; e_sel = r; e_val = '0; e_ea = '0;
        case (m)
            3'd0: begin e_reg = 1'b1; e_ea = {13'b0, r}; end
            3'd1: e_ea = base;
            3'd2: begin e_ea = base; e_wb = 1'b1; e_val = base + step; end
            3'd3: begin ptr = base; e_wb = 1'b1; e_val = base + 16'd2;
                        if (ptr[0]) e_err = 1'b1; else e_ea = mem_f(ptr); end
            3'd4: begin e_ea = base - step; e_wb = 1'b1; e_val = base - step; end
            3'd5: begin ptr = base - 16'd2; e_wb = 1'b1; e_val = ptr;
                        if (ptr[0]) e_err = 1'b1; else e_ea = mem_f(ptr); end
            default: begin
                pc = load_img[7];
                if (pc[0]) e_err = 1'b1;
                else begin
                    sum = mem_f(pc) + ((r == 3'd7) ? pc + 16'd2 : base);
                    e_wb = 1'b1; e_sel = 3'd7; e_val = pc + 16'd2;
                    if (m == 3'd6) e_ea = sum;
                    else if (sum[0]) e_err = 1'b1;
                    else e_ea = mem_f(sum);
                end
            end
        endcase
        if (!e_err && m != 0 && !b && e_ea[0]) e_err = 1'b1;
    endtask

    task automatic run_op(input logic [2:0] m, input logic [2:0] r, input logic b,
                          input bit poke, input int exp_lat, input string req);
        logic e_err, e_reg, e_wb; logic [15:0] e_ea, e_val; logic [2:0] e_sel;
        logic [15:0] exp_rf [8];
        int waited;
        bit seen;
        @(negedge clk); load_en = 1'b1;
        @(negedge clk); load_en = 1'b0;
        predict(m, r, b, e_err, e_ea, e_reg, e_wb, e_sel, e_val);
        for (int i = 0; i < 8; i++) exp_rf[i] = load_img[i];
        if (e_wb && !e_err) exp_rf[e_sel] = e_val;
        spec_mode = m; spec_reg = r; is_byte = b; start = 1'b1;
        @(negedge clk); start = 1'b0;
        waited = 0; seen = 0;
        for (int c = 0; c < 64; c++) begin
            if (done || odd_fault) begin seen = 1; break; end
            if (poke && c == 0) begin
                start = 1'b1; spec_mode = 3'd0; spec_reg = ~r; is_byte = ~b;
            end else start = 1'b0;
            @(negedge clk); waited++;
        end
        start = 1'b0;
        check(seen, req, "watchdog completion", 16'(waited), 16'd64);
        if (!seen) return;
        check(odd_fault == e_err, req, "odd_fault", {15'b0, odd_fault}, {15'b0, e_err});
        check(done == !e_err, req, "done", {15'b0, done}, {15'b0, !e_err});
        if (!e_err) begin
            check(ea == e_ea, req, "ea", ea, e_ea);
            check(ea_is_reg == e_reg, req, "ea_is_reg", {15'b0, ea_is_reg}, {15'b0, e_reg});
        end
        if (exp_lat >= 0)
            check(waited == exp_lat, req, "latency", 16'(waited), 16'(exp_lat));
        @(negedge clk);
        check(!done && !odd_fault, "R9", "pulse width", {15'b0, done}, 16'd0);
        for (int i = 0; i < 8; i++)
            check(rf[i] == exp_rf[i], req, $sformatf("reg%0d", i), rf[i], exp_rf[i]);
    endtask

    task automatic set_regs(input logic [15:0] v0, input logic [15:0] v6,
                            input logic [15:0] v7);
        for (int i = 0; i < 8; i++) load_img[i] = 16'h1000 + 16'(i * 16'h0102);
        load_img[0] = v0; load_img[6] = v6; load_img[7] = v7;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual %0d expected <190000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) load_img[i] = '0;
        repeat (3) @(negedge clk);
        check(!done && !odd_fault && !rf_we && !mem_req_valid, "R9", "reset outputs",
              {12'b0, done, odd_fault, rf_we, mem_req_valid}, 16'd0);
        rst_n = 1'b1;

        set_regs(16'h0345, 16'h2000, 16'h0400);
        run_op(3'd0, 3'd5, 1'b0, 0, 0, "R1");
        run_op(3'd1, 3'd0, 1'b1, 0, 0, "R2");    // byte odd ea allowed (R8)
        run_op(3'd1, 3'd0, 1'b0, 0, 0, "R8");    // word odd ea faults
        run_op(3'd2, 3'd0, 1'b1, 0, 0, "R3");
        run_op(3'd4, 3'd0, 1'b1, 0, 0, "R3");
        set_regs(16'h0344, 16'h2000, 16'h0400);
        run_op(3'd2, 3'd0, 1'b0, 0, 0, "R3");
        run_op(3'd4, 3'd0, 1'b0, 0, 0, "R3");
        run_op(3'd2, 3'd6, 1'b1, 0, 0, "R4");
        run_op(3'd4, 3'd6, 1'b1, 0, 0, "R4");
        run_op(3'd2, 3'd7, 1'b1, 0, 0, "R4");    // immediate, R7
        run_op(3'd3, 3'd0, 1'b1, 0, -1, "R5");
        run_op(3'd5, 3'd0, 1'b1, 0, -1, "R5");
        run_op(3'd3, 3'd7, 1'b0, 0, -1, "R7");   // absolute
        run_op(3'd6, 3'd7, 1'b1, 0, -1, "R7");   // relative
        run_op(3'd7, 3'd7, 1'b1, 0, -1, "R7");   // relative deferred
        run_op(3'd6, 3'd0, 1'b1, 0, -1, "R6");
        run_op(3'd7, 3'd0, 1'b1, 0, -1, "R6");
        set_regs(16'h0344, 16'h2000, 16'h0401);
        run_op(3'd6, 3'd0, 1'b0, 0, -1, "R8");   // odd counter
        set_regs(16'h0341, 16'h2000, 16'h0400);
        run_op(3'd3, 3'd0, 1'b0, 0, -1, "R8");   // odd pointer address
        set_regs(16'h0344, 16'h2000, 16'h0400);
        run_op(3'd5, 3'd0, 1'b0, 1, -1, "R11");
        run_op(3'd7, 3'd2, 1'b0, 1, -1, "R11");

        for (int k = 0; k < 400; k++) begin
            for (int i = 0; i < 8; i++) begin
                load_img[i] = 16'($urandom);
                if (($urandom % 4) != 0) load_img[i][0] = 1'b0;
            end
            run_op(3'($urandom), 3'($urandom), 1'($urandom), ($urandom % 5) == 0,
                   -1, "R10");
        end

        check(!odd_seen, "R8", "odd memory request", {15'b0, odd_seen}, 16'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule